// File: doc/BRIEF.md
# Self-Selecting Decimal/Binary Digit Adder

This combinational block adds two 4-bit unsigned operands. It picks its arithmetic from the operand values on every evaluation. If both operands are legal decimal digits (0 to 9), they are summed as packed BCD. The block then returns one decimal digit and a decimal carry worth ten. If either operand is 10 or above, the pair is summed as plain unsigned binary. The block then returns the low four bits and a carry worth sixteen. A mode flag tells the consumer which reading of the outputs applies.

Both the main sum and the decimal adjustment are formed by 4-bit adders. In each adder, every carry is computed directly from per-bit generate and propagate terms as a flat sum of products, so no carry passes from bit to bit. The decimal adjustment always adds six to the binary sum. It keeps that result only when a decimal carry is due. The block holds no state and has no clock.

Top module: `dual_mode_adder`

## Requirements
- R1: `bcd_flag_o` is 1 exactly when both `op_a` and `op_b` are 9 or less, and 0 when either is in 10..15.
- R2: With `bcd_flag_o` = 1, `sum_o` is always 9 or less and `carry_o`*10 + `sum_o` equals `op_a` + `op_b`.
- R3: With `bcd_flag_o` = 0, {`carry_o`,`sum_o`} read as a 5-bit unsigned value equals `op_a` + `op_b`.
- R4: 9 + 9 gives `sum_o` = 8, `carry_o` = 1, `bcd_flag_o` = 1.
- R5: 15 + 15 gives `sum_o` = 4'b1110, `carry_o` = 1, `bcd_flag_o` = 0.
- R6: 0 + 0 gives `sum_o` = 0, `carry_o` = 0, `bcd_flag_o` = 1.
- R7: In decimal mode, a binary total of 9 or less appears unchanged on `sum_o`, with `carry_o` = 0.
- R8: An operand of exactly 10 forces binary mode even when the other operand is 0 (10 + 0 gives `sum_o` = 4'b1010, `carry_o` = 0, `bcd_flag_o` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First unsigned operand |
| op_b | input | 4 | Second unsigned operand |
| sum_o | output | 4 | Decimal digit or low binary sum bits |
| carry_o | output | 1 | Decimal carry (worth 10) or binary carry (worth 16) |
| bcd_flag_o | output | 1 | 1: outputs are BCD; 0: outputs are binary |

## Verification
The checker evaluates its properties only when both operands carry known 0/1 values. It assumes that any pair of 4-bit values may appear, since the block has no input contract beyond width. The stimulus drives every operand pair once, plus the named corner pairs. It changes the operands just after a clock edge and reads the outputs half a period later, so the combinational paths have settled before each comparison.

// File: rtl/dual_mode_adder_pkg.sv
package dual_mode_adder_pkg;
    localparam int DIGIT_W = 4;
    localparam int MAX_DIGIT = 9;
    localparam logic [DIGIT_W-1:0] DEC_ADJUST = DIGIT_W'(16 - (MAX_DIGIT + 1));
    localparam int N_OPS = 2;

    typedef struct packed {
        logic [DIGIT_W-1:0] sum;
        logic               carry;
        logic               bcd;
    } add_result_t;
endpackage

// File: rtl/lookahead_add.sv
module lookahead_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] gen_bits;
    logic [W-1:0] prop_bits;
    logic [W:0]   carry_d;

    assign gen_bits  = a & b;
    assign prop_bits = a ^ b;

    // Each carry is a flat OR of product terms over generate/propagate.
    always_comb begin
        logic term;
        logic acc;
        carry_d[0] = cin;
        for (int i = 1; i <= W; i++) begin
            term = cin;
            for (int k = 0; k < i; k++) term = term & prop_bits[k];
            acc = term;
            for (int j = 0; j < i; j++) begin
                term = gen_bits[j];
                for (int k = j + 1; k < i; k++) term = term & prop_bits[k];
                acc = acc | term;
            end
            carry_d[i] = acc;
        end
    end

    assign sum  = prop_bits ^ carry_d[W-1:0];
    assign cout = carry_d[W];
endmodule

// File: rtl/digit_range_detect.sv
module digit_range_detect
    import dual_mode_adder_pkg::*;
(
    input  logic [DIGIT_W-1:0] val,
    output logic               over_nine
);
    // True for 10..15: top bit set together with either middle bit.
    assign over_nine = val[3] & (val[2] | val[1]);
endmodule

// File: rtl/dual_mode_adder.sv
module dual_mode_adder
    import dual_mode_adder_pkg::*;
(
    input  logic [DIGIT_W-1:0] op_a,
    input  logic [DIGIT_W-1:0] op_b,
    output logic [DIGIT_W-1:0] sum_o,
    output logic               carry_o,
    output logic               bcd_flag_o
);
    logic [DIGIT_W-1:0] ops [N_OPS];
    logic [N_OPS-1:0]   over_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar n = 0; n < N_OPS; n++) begin : g_range
        digit_range_detect u_rng (
            .val       (ops[n]),
            .over_nine (over_q[n])
        );
    end

    logic [DIGIT_W-1:0] raw_sum;
    logic               raw_cout;
    logic [DIGIT_W-1:0] adj_sum;
    logic               adj_cout;

    lookahead_add #(.W(DIGIT_W)) u_main (
        .a    (op_a),
        .b    (op_b),
        .cin  (1'b0),
        .sum  (raw_sum),
        .cout (raw_cout)
    );

    // Speculative +6: its carry-out flags totals 10..15, raw_cout flags 16..18.
    lookahead_add #(.W(DIGIT_W)) u_adjust (
        .a    (raw_sum),
        .b    (DEC_ADJUST),
        .cin  (1'b0),
        .sum  (adj_sum),
        .cout (adj_cout)
    );

    add_result_t result_d;

    always_comb begin
        logic dec_carry;
        dec_carry       = raw_cout | adj_cout;
        result_d.bcd    = ~|over_q;
        if (result_d.bcd) begin
            result_d.carry = dec_carry;
            result_d.sum   = dec_carry ? adj_sum : raw_sum;
        end else begin
            result_d.carry = raw_cout;
            result_d.sum   = raw_sum;
        end
    end

    assign sum_o      = result_d.sum;
    assign carry_o    = result_d.carry;
    assign bcd_flag_o = result_d.bcd;
endmodule

// File: rtl/dual_mode_adder_chk.sv
module dual_mode_adder_chk (
    input logic [3:0] op_a,
    input logic [3:0] op_b,
    input logic [3:0] sum_o,
    input logic       carry_o,
    input logic       bcd_flag_o
);
    always_comb begin
        if (!$isunknown({op_a, op_b, sum_o, carry_o, bcd_flag_o})) begin
            a_r1_flag_range: assert (bcd_flag_o == (op_a < 4'd10 && op_b < 4'd10));
            if (bcd_flag_o) begin
                a_r2_digit_legal: assert (sum_o < 4'd10);
                a_r2_decimal_value: assert ((32'(carry_o) * 10 + 32'(sum_o)) == (32'(op_a) + 32'(op_b)));
                if ((5'(op_a) + 5'(op_b)) < 5'd10) begin
                    a_r7_pass_through: assert (!carry_o && sum_o == op_a + op_b);
                end
            end else begin
                a_r3_binary_value: assert ({carry_o, sum_o} == 5'(op_a) + 5'(op_b));
            end
        end
    end
endmodule

bind dual_mode_adder dual_mode_adder_chk u_chk (.*);

// File: tb/tb_dual_mode_adder.sv
module tb_dual_mode_adder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [3:0] sum_o;
    logic       carry_o;
    logic       bcd_flag_o;

    dual_mode_adder dut (
        .op_a       (op_a),
        .op_b       (op_b),
        .sum_o      (sum_o),
        .carry_o    (carry_o),
        .bcd_flag_o (bcd_flag_o)
    );

    typedef struct {
        int    a;
        int    b;
        int    sum;
        int    carry;
        int    flag;
        string tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;

    // Reference model written from the requirements.
    task automatic drive(input int a, input int b, input string tag);
        exp_t e;
        int   tot;
        @(posedge clk);
        #1;
        op_a = 4'(a);
        op_b = 4'(b);
        tot  = a + b;
        e.a = a; e.b = b; e.tag = tag;
        e.flag = (a <= 9 && b <= 9) ? 1 : 0;
        if (e.flag == 1) begin
            e.carry = (tot >= 10) ? 1 : 0;
            e.sum   = tot % 10;
        end else begin
            e.carry = tot / 16;
            e.sum   = tot % 16;
        end
        q.push_back(e);
    endtask

    // Monitor: samples mid-cycle, half a period after the driver.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (int'(bcd_flag_o) != e.flag) begin
                errors++;
                $display("FAIL R1 a=%0d b=%0d flag actual=%0d expected=%0d",
                         e.a, e.b, bcd_flag_o, e.flag);
            end
            checks++;
            if (int'(sum_o) != e.sum || int'(carry_o) != e.carry) begin
                errors++;
                $display("FAIL %s a=%0d b=%0d actual sum=%0d carry=%0d expected sum=%0d carry=%0d",
                         e.tag, e.a, e.b, sum_o, carry_o, e.sum, e.carry);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 0, "R6");      // first item: zero operands, reset-like state
        drive(9, 9, "R4");
        drive(15, 15, "R5");
        drive(10, 0, "R8");
        drive(0, 10, "R8");
        drive(9, 0, "R7");
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (a > 9 || b > 9)   drive(a, b, "R3");
                else if (a + b <= 9)  drive(a, b, "R7");
                else                  drive(a, b, "R2");
            end
        end
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired with %0d items pending", q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule